// File: doc/BRIEF.md
# Transposed Monochrome Frame Scanout

This block drives a portrait TFT panel with a landscape monochrome picture held in a frame RAM. Each RAM word holds four dots. It sets the pixel rate and produces the line and frame timing. Along the way it fetches the dot for every panel pixel, so the panel shows black or white RGB and never waits on a fetch.

The panel scans along its short side, so every panel line is one column of the picture. The engine walks the dot index with the axes swapped. Each dot covers three panel pixels in each direction. Above the picture sit `BLANK_ROWS` black dot rows. Below it the bottom picture row repeats to the edge of the panel. Any panel line past the last picture column is black.

The RAM writer lives elsewhere. Only the read port is used here, and it runs at the pixel rate, apart from writes.

Top module: `frame_scanout`

## Requirements
- R1: While `rst_ni` is low, and for the first pixel tick after release, `de_o`=0, `hsync_no`=1, `vsync_no`=1, `rgb_o`=0. While `rst_ni` is low, `pix_ce_o`=0.
- R2: After `n` clock edges since reset release, `pix_ce_o` is 1 exactly when `n mod PCLK_DIV == PCLK_DIV-1`. All outputs except `pix_ce_o` change only on edges where `pix_ce_o` was high.
- R3: A line is H_ACT+H_FP+H_SW+H_BP ticks long, with pixel index h counted from 0. `hsync_no` is low for h in [H_ACT+H_FP, H_ACT+H_FP+H_SW). `de_o` is high only for h < H_ACT on active lines.
- R4: A frame is V_ACT+V_FP+V_SW+V_BP lines long, with line index v counted from 0. `vsync_no` is low for the whole of each line with v in [V_ACT+V_FP, V_ACT+V_FP+V_SW). `de_o` is 0 on lines with v >= V_ACT.
- R5: Active pixel (h, v) shows dot column c = v/3 and display dot row r = h/3. Each dot therefore fills a 3 x 3 pixel square.
- R6: For picture row i, the dot index is i*IMG_COLS + c. It is fetched from RAM word index/4 on `ram_addr_o`, bit index mod 4 of `ram_data_i`.
- R7: Display dot rows r < BLANK_ROWS are black.
- R8: Display dot rows r >= BLANK_ROWS+IMG_ROWS show picture row IMG_ROWS-1.
- R9: Dot columns c >= IMG_COLS are black.
- R10: A fetched 1 drives every bit of `rgb_o` to 1, and a fetched 0 drives it to 0. Outside `de_o`, `rgb_o` is 0.
- R11: `ram_rd_en_o` equals `pix_ce_o`. The RAM has one read cycle of latency. Outputs after the k-th tick edge describe position k-2 of the raster, with sync, enable and colour aligned to each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pix_ce_o | output | 1 | Pixel tick, one clock in every PCLK_DIV |
| hsync_no | output | 1 | Line sync, active low |
| vsync_no | output | 1 | Frame sync, active low |
| de_o | output | 1 | Data enable |
| rgb_o | output | RGB_W | Pixel colour, all zeros or all ones |
| ram_rd_en_o | output | 1 | Frame RAM read enable |
| ram_addr_o | output | ADDR_W | Frame RAM word address |
| ram_data_i | input | 4 | Frame RAM read data, four dots |

## Verification
The bench builds the engine with a 24 x 19 tick raster, an 18-pixel active width and 15 active lines. The picture is 4 columns by 3 rows, with 2 blank rows and a pixel divider of 2. Those sizes let two full frames run through in about two thousand cycles. Within them, every panel pixel is compared with an arithmetic model.

One column lies past the picture, one display row lies past its bottom, and the two blank rows sit on top. So every fill rule, every nibble bit position and every porch and sync edge is reached in each frame. A reset in the middle of a frame then shows that the raster restarts cleanly.

// File: rtl/fs_pkg.sv
package fs_pkg;
  localparam int DOTS_PER_WORD = 4;
  localparam int SEL_W         = 2;

  typedef struct packed {
    logic de;
    logic hsync_n;
    logic vsync_n;
  } fs_ctrl_t;

  localparam fs_ctrl_t CTRL_IDLE = '{de: 1'b0, hsync_n: 1'b1, vsync_n: 1'b1};
endpackage

// File: rtl/fs_timing.sv
module fs_timing
  import fs_pkg::*;
#(
  parameter int PCLK_DIV = 2,
  parameter int H_ACT    = 480,
  parameter int H_FP     = 10,
  parameter int H_SW     = 4,
  parameter int H_BP     = 10,
  parameter int V_ACT    = 960,
  parameter int V_FP     = 8,
  parameter int V_SW     = 2,
  parameter int V_BP     = 8
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  output logic     ce_o,
  output logic     h_act_o,
  output logic     v_act_o,
  output logic     line_end_o,
  output logic     frame_end_o,
  output fs_ctrl_t ctrl_o
);
  localparam int H_TOT = H_ACT + H_FP + H_SW + H_BP;
  localparam int V_TOT = V_ACT + V_FP + V_SW + V_BP;
  localparam int H_W   = $clog2(H_TOT);
  localparam int V_W   = $clog2(V_TOT);
  localparam int DIV_W = (PCLK_DIV > 1) ? $clog2(PCLK_DIV) : 1;

  logic [H_W-1:0] h_q;
  logic [V_W-1:0] v_q;
  logic           ce;

  if (PCLK_DIV > 1) begin : g_div
    logic [DIV_W-1:0] div_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             div_q <= '0;
      else if (div_q == DIV_W'(PCLK_DIV - 1))  div_q <= '0;
      else                                     div_q <= div_q + 1'b1;
    end
    assign ce = rst_ni && (div_q == DIV_W'(PCLK_DIV - 1));

    AST_CE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ce |=> !ce); // R2
  end else begin : g_nodiv
    assign ce = rst_ni;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q <= '0;
      v_q <= '0;
    end else if (ce) begin
      if (h_q == H_W'(H_TOT - 1)) begin
        h_q <= '0;
        v_q <= (v_q == V_W'(V_TOT - 1)) ? '0 : v_q + 1'b1;
      end else begin
        h_q <= h_q + 1'b1;
      end
    end
  end

  assign ce_o        = ce;
  assign h_act_o     = h_q < H_W'(H_ACT);
  assign v_act_o     = v_q < V_W'(V_ACT);
  assign line_end_o  = h_q == H_W'(H_TOT - 1);
  assign frame_end_o = v_q == V_W'(V_TOT - 1);

  always_comb begin
    ctrl_o.de      = h_act_o && v_act_o;
    ctrl_o.hsync_n = !((h_q >= H_W'(H_ACT + H_FP)) && (h_q < H_W'(H_ACT + H_FP + H_SW)));
    ctrl_o.vsync_n = !((v_q >= V_W'(V_ACT + V_FP)) && (v_q < V_W'(V_ACT + V_FP + V_SW)));
  end

  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce |=> ($stable(h_q) && $stable(v_q))); // R2
endmodule

// File: rtl/fs_dot_walker.sv
module fs_dot_walker
  import fs_pkg::*;
#(
  parameter int H_ACT      = 480,
  parameter int V_ACT      = 960,
  parameter int IMG_COLS   = 320,
  parameter int IMG_ROWS   = 97,
  parameter int BLANK_ROWS = 4,
  parameter int ADDR_W     = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_i,
  input  logic              h_act_i,
  input  logic              v_act_i,
  input  logic              line_end_i,
  input  logic              frame_end_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic              dark_o
);
  localparam int ROW_MAX = (H_ACT / 3 > BLANK_ROWS + IMG_ROWS) ? H_ACT / 3 : BLANK_ROWS + IMG_ROWS;
  localparam int COL_MAX = (V_ACT / 3 > IMG_COLS) ? V_ACT / 3 : IMG_COLS;
  localparam int ROW_W   = $clog2(ROW_MAX + 1);
  localparam int COL_W   = $clog2(COL_MAX + 1);
  localparam int IDX_W   = $clog2(IMG_COLS * IMG_ROWS);

  logic [ROW_W-1:0] row_q, row_nx;
  logic [COL_W-1:0] col_q;
  logic [1:0]       row_sub_q, col_sub_q;
  logic [IDX_W-1:0] ptr_q, base_q, base_nx;

  assign row_nx  = row_q + 1'b1;
  // column base saturates at the last picture column so the pointer stays in range
  assign base_nx = (col_q < COL_W'(IMG_COLS - 1)) ? base_q + 1'b1 : base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_q     <= '0;
      row_sub_q <= '0;
      col_q     <= '0;
      col_sub_q <= '0;
      base_q    <= '0;
      ptr_q     <= '0;
    end else if (ce_i) begin
      if (line_end_i) begin
        row_q     <= '0;
        row_sub_q <= '0;
        if (frame_end_i) begin
          col_q     <= '0;
          col_sub_q <= '0;
          base_q    <= '0;
          ptr_q     <= '0;
        end else if (v_act_i && col_sub_q == 2'd2) begin
          col_sub_q <= '0;
          col_q     <= col_q + 1'b1;
          base_q    <= base_nx;
          ptr_q     <= base_nx;
        end else begin
          if (v_act_i) col_sub_q <= col_sub_q + 1'b1;
          ptr_q <= base_q;
        end
      end else if (h_act_i) begin
        if (row_sub_q == 2'd2) begin
          row_sub_q <= '0;
          row_q     <= row_nx;
          if (row_nx > ROW_W'(BLANK_ROWS) && row_nx < ROW_W'(BLANK_ROWS + IMG_ROWS))
            ptr_q <= ptr_q + IDX_W'(IMG_COLS);
        end else begin
          row_sub_q <= row_sub_q + 1'b1;
        end
      end
    end
  end

  assign addr_o = ADDR_W'(ptr_q[IDX_W-1:SEL_W]);
  assign sel_o  = ptr_q[SEL_W-1:0];
  assign dark_o = (row_q < ROW_W'(BLANK_ROWS)) || (col_q >= COL_W'(IMG_COLS));

  AST_IDX_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(ptr_q) < 32'(IMG_COLS * IMG_ROWS)); // R6
  AST_BLANK_AT_BASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (row_q < ROW_W'(BLANK_ROWS + 1)) |-> (ptr_q == base_q)); // R7
  AST_FILL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_i && h_act_i && !line_end_i && row_q >= ROW_W'(BLANK_ROWS + IMG_ROWS - 1))
      |=> (ptr_q == $past(ptr_q))); // R8
endmodule

// File: rtl/fs_out_stage.sv
module fs_out_stage
  import fs_pkg::*;
#(
  parameter int RGB_W = 24
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     ce_i,
  input  fs_ctrl_t                 ctrl_i,
  input  logic                     dark_i,
  input  logic [SEL_W-1:0]         sel_i,
  input  logic [DOTS_PER_WORD-1:0] ram_data_i,
  output logic                     de_o,
  output logic                     hsync_no,
  output logic                     vsync_no,
  output logic [RGB_W-1:0]         rgb_o
);
  fs_ctrl_t         s1_ctrl_q, s2_ctrl_q;
  logic             s1_dark_q;
  logic [SEL_W-1:0] s1_sel_q;
  logic             dot;

  assign dot = s1_ctrl_q.de && !s1_dark_q && ram_data_i[s1_sel_q];

  // stage 1 waits for the read issued on the same tick; stage 2 meets the data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_ctrl_q <= CTRL_IDLE;
      s1_dark_q <= 1'b1;
      s1_sel_q  <= '0;
      s2_ctrl_q <= CTRL_IDLE;
      rgb_o     <= '0;
    end else if (ce_i) begin
      s1_ctrl_q <= ctrl_i;
      s1_dark_q <= dark_i;
      s1_sel_q  <= sel_i;
      s2_ctrl_q <= s1_ctrl_q;
      rgb_o     <= dot ? '1 : '0;
    end
  end

  assign de_o     = s2_ctrl_q.de;
  assign hsync_no = s2_ctrl_q.hsync_n;
  assign vsync_no = s2_ctrl_q.vsync_n;

  AST_DE_SYNC_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    de_o |-> (hsync_no && vsync_no)); // R3
  AST_RGB_MONO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rgb_o == '0) || (rgb_o == '1)); // R10
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> ($stable(rgb_o) && $stable(de_o))); // R11
endmodule

// File: rtl/frame_scanout.sv
module frame_scanout
  import fs_pkg::*;
#(
  parameter int PCLK_DIV   = 2,
  parameter int H_ACT      = 480,
  parameter int H_FP       = 10,
  parameter int H_SW       = 4,
  parameter int H_BP       = 10,
  parameter int V_ACT      = 960,
  parameter int V_FP       = 8,
  parameter int V_SW       = 2,
  parameter int V_BP       = 8,
  parameter int IMG_COLS   = 320,
  parameter int IMG_ROWS   = 97,
  parameter int BLANK_ROWS = 4,
  parameter int ADDR_W     = 14,
  parameter int RGB_W      = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              pix_ce_o,
  output logic              hsync_no,
  output logic              vsync_no,
  output logic              de_o,
  output logic [RGB_W-1:0]  rgb_o,
  output logic              ram_rd_en_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  input  logic [3:0]        ram_data_i
);
  logic             ce, h_act, v_act, line_end, frame_end, dark;
  logic [SEL_W-1:0] sel;
  fs_ctrl_t         ctrl;

  fs_timing #(
    .PCLK_DIV(PCLK_DIV), .H_ACT(H_ACT), .H_FP(H_FP), .H_SW(H_SW), .H_BP(H_BP),
    .V_ACT(V_ACT), .V_FP(V_FP), .V_SW(V_SW), .V_BP(V_BP)
  ) u_timing (
    .clk_i, .rst_ni,
    .ce_o(ce), .h_act_o(h_act), .v_act_o(v_act),
    .line_end_o(line_end), .frame_end_o(frame_end), .ctrl_o(ctrl)
  );

  fs_dot_walker #(
    .H_ACT(H_ACT), .V_ACT(V_ACT), .IMG_COLS(IMG_COLS), .IMG_ROWS(IMG_ROWS),
    .BLANK_ROWS(BLANK_ROWS), .ADDR_W(ADDR_W)
  ) u_walker (
    .clk_i, .rst_ni, .ce_i(ce), .h_act_i(h_act), .v_act_i(v_act),
    .line_end_i(line_end), .frame_end_i(frame_end),
    .addr_o(ram_addr_o), .sel_o(sel), .dark_o(dark)
  );

  fs_out_stage #(.RGB_W(RGB_W)) u_out (
    .clk_i, .rst_ni, .ce_i(ce), .ctrl_i(ctrl), .dark_i(dark), .sel_i(sel),
    .ram_data_i, .de_o, .hsync_no, .vsync_no, .rgb_o
  );

  assign pix_ce_o    = ce;
  assign ram_rd_en_o = ce;
endmodule

// File: tb/tb_frame_scanout.sv
`timescale 1ns/1ps
module tb_frame_scanout;
  localparam int DIV = 2;
  localparam int HA = 18, HF = 2, HS = 2, HB = 2, HT = HA + HF + HS + HB;
  localparam int VA = 15, VF = 1, VS = 2, VB = 1, VT = VA + VF + VS + VB;
  localparam int IC = 4, IR = 3, BR = 2, AW = 4, RW = 24;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          pix_ce, hs_n, vs_n, de, rd_en;
  logic [RW-1:0] rgb;
  logic [AW-1:0] addr;
  logic [3:0]    ram_q = '0;
  logic [3:0]    mem [16];
  int            n_tests = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  frame_scanout #(
    .PCLK_DIV(DIV), .H_ACT(HA), .H_FP(HF), .H_SW(HS), .H_BP(HB),
    .V_ACT(VA), .V_FP(VF), .V_SW(VS), .V_BP(VB),
    .IMG_COLS(IC), .IMG_ROWS(IR), .BLANK_ROWS(BR), .ADDR_W(AW), .RGB_W(RW)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .pix_ce_o(pix_ce), .hsync_no(hs_n), .vsync_no(vs_n),
    .de_o(de), .rgb_o(rgb), .ram_rd_en_o(rd_en), .ram_addr_o(addr), .ram_data_i(ram_q)
  );

  always @(posedge clk) if (rd_en) ram_q <= mem[addr];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(de == 1'b0,   req, "de idle",    int'(de),   0);
    chk(hs_n == 1'b1, req, "hsync idle", int'(hs_n), 1);
    chk(vs_n == 1'b1, req, "vsync idle", int'(vs_n), 1);
    chk(rgb == '0,    req, "rgb idle",   int'(rgb),  0);
  endtask

  task automatic chk_pos(input int p);
    int h, v, c, r, ir, idx, e_rgb;
    bit e_de, e_hs, e_vs;
    string tag;
    h = p % HT;
    v = (p / HT) % VT;
    e_de = (h < HA) && (v < VA);
    e_hs = !((h >= HA + HF) && (h < HA + HF + HS));
    e_vs = !((v >= VA + VF) && (v < VA + VF + VS));
    e_rgb = 0;
    tag = "R10";
    if (e_de) begin
      c = v / 3;
      r = h / 3;
      if (c >= IC)          tag = "R9";
      else if (r < BR)      tag = "R7";
      else begin
        ir  = (r - BR > IR - 1) ? IR - 1 : r - BR;
        tag = (r - BR > IR - 1) ? "R8" : "R6";
        idx = ir * IC + c;
        e_rgb = mem[idx / 4][idx % 4] ? (1 << RW) - 1 : 0;
      end
    end
    chk(de == e_de,   "R3/R4", "de",    int'(de),   int'(e_de));
    chk(hs_n == e_hs, "R3",    "hsync", int'(hs_n), int'(e_hs));
    chk(vs_n == e_vs, "R4",    "vsync", int'(vs_n), int'(e_vs));
    chk(int'(rgb) == e_rgb, {tag, " R5 R11"}, "rgb", int'(rgb), e_rgb);
  endtask

  task automatic run(input int nclk);
    int n = 0, k = 0;
    bit ce_prev = 1'b0;
    repeat (nclk) begin
      @(negedge clk);
      n++;
      if (ce_prev) k++;
      chk(pix_ce == ((n % DIV) == DIV - 1), "R2", "pix_ce", int'(pix_ce), int'((n % DIV) == DIV - 1));
      chk(rd_en == pix_ce, "R11", "rd_en", int'(rd_en), int'(pix_ce));
      if (k < 2) chk_idle("R1");
      else       chk_pos(k - 2);
      ce_prev = pix_ce;
    end
  endtask

  initial begin
    for (int a = 0; a < 16; a++) mem[a] = 4'((a * 5 + 9) % 16);
    repeat (3) @(negedge clk);
    chk_idle("R1");
    chk(pix_ce == 1'b0, "R1", "pix_ce in reset", int'(pix_ce), 0);
    rst_n = 1'b1;
    run(2 * HT * VT * DIV + 20);
    rst_n = 1'b0;
    @(negedge clk);
    chk_idle("R1");
    chk(pix_ce == 1'b0, "R1", "pix_ce in reset", int'(pix_ce), 0);
    @(negedge clk);
    rst_n = 1'b1;
    run(HT * VT * DIV / 2);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule